// File: doc/BRIEF.md
# Event-Mapped Delayed Pulse Outputs

This block sits behind the decoder of a timing-distribution receiver. On every frame clock it takes one 8-bit event code, looks it up in a 256-entry action table, and applies the actions found there to a bank of trigger outputs. Each output index has two pins. One is a pulse pin that fires after a programmable delay for a programmable width, both counted in frame clocks. The other is a level pin that acts like a flip-flop: it is set by some codes and cleared by others. Each receiver has its own table, so one broadcast code can start a pulse on one output, set a level on a second and clear a third. An entry can also flag its code as a source of a sticky interrupt request.

Software fills the action table through a simple write port. It loads each output's delay and width through a per-channel configuration port. It acknowledges the interrupt by pulsing a clear input. Code 0x00 is the idle code of the link and never acts.

Top module: `evmap_pulse_unit`

## Requirements
- R1: Code 0x00 causes no action on any output and does not raise the interrupt, whatever table entry 0 holds.
- R2: For output i, a table entry holds the pulse-trigger bit at position i, the set bit at position N_OUT+i, the reset bit at position 2*N_OUT+i, and the interrupt bit at position 3*N_OUT. An entry written at one clock edge governs codes sampled at later edges.
- R3: A pulse trigger for a code sampled at edge k makes the pulse pin rise at edge k+1+D, where D is the channel's delay (D=0 rises at k+1).
- R4: A triggered pulse stays high for exactly W frame clocks, where W is the channel's width as programmed when the trigger took effect.
- R5: A trigger with width 0 produces no pulse and ends any delay or pulse in progress on that channel.
- R6: A trigger that arrives while a channel is delaying or pulsing restarts that channel's delay from its beginning.
- R7: A set bit drives the level pin high at edge k+1, and a reset bit drives it low at edge k+1. With neither bit present the level pin holds.
- R8: When one entry holds both the set bit and the reset bit of the same output, the level pin goes low.
- R9: The interrupt bit sets the sticky interrupt output at edge k+1. The output stays high until the clear input is sampled high, and a set in the same edge beats the clear.
- R10: The outputs act independently: one code may pulse, set and reset different outputs at once.
- R11: Synchronous reset drives all pulse pins, level pins and the interrupt output low, clears every delay and width to 0, and drops any code already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_code | input | CODE_W | Decoded event code, one per clock; 0 is idle |
| tbl_we | input | 1 | Action table write enable |
| tbl_addr | input | CODE_W | Action table entry to write |
| tbl_wdata | input | 3*N_OUT+1 | Action table entry contents |
| cfg_we | input | 1 | Channel timing write enable |
| cfg_ch | input | $clog2(N_OUT) | Channel whose timing is written |
| cfg_delay | input | CNT_W | Delay in frame clocks |
| cfg_width | input | CNT_W | Width in frame clocks, 0 suppresses |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| pulse_out | output | N_OUT | Delayed pulse pins |
| level_out | output | N_OUT | Set/reset level pins |
| irq_out | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with its defaults: four outputs, 8-bit codes and 16-bit counters. Four outputs give room for one code to pulse, set and reset separate channels in the same cycle, and for an entry that holds set and reset of one output alongside a plain set of another. The counters are 16 bits wide, but the bench programs delays of 0 to 5 and widths of 0 to 4. That keeps many pulses, retriggers during a delay and retriggers during a pulse inside a run of a few thousand cycles. Random codes are drawn from the first sixteen table entries, so code 0 with a fully loaded entry and frequent reuse of the same entries both come up often.

// File: rtl/evpulse_pkg.sv
package evpulse_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_DELAY  = 2'd1,
    CH_ACTIVE = 2'd2
  } ch_state_e;
endpackage

// File: rtl/evmap_table.sv
// Action lookup: block-RAM style table, synchronous read-first port,
// with the idle-code mask applied to the registered read data.
module evmap_table #(
  parameter int CODE_W = 8,
  parameter int ENT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              we,
  input  logic [CODE_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  output logic [ENT_W-1:0]  act
);
  localparam int DEPTH = 1 << CODE_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic             live_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[code];
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= (code != '0);
  end

  assign act = live_q ? rd_q : '0;
endmodule

// File: rtl/evmap_pulse_chan.sv
// One delayed-pulse generator: delay count, then width count.
module evmap_pulse_chan
  import evpulse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] width,
  output logic             pulse
);
  ch_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] w_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= CH_IDLE;
      cnt    <= '0;
      w_hold <= '0;
      pulse  <= 1'b0;
    end else if (trig) begin
      w_hold <= width;
      if (width == '0) begin
        st    <= CH_IDLE;
        pulse <= 1'b0;
      end else if (delay == '0) begin
        st    <= CH_ACTIVE;
        cnt   <= width - 1'b1;
        pulse <= 1'b1;
      end else begin
        st    <= CH_DELAY;
        cnt   <= delay - 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      case (st)
        CH_DELAY: begin
          if (cnt == '0) begin
            st    <= CH_ACTIVE;
            cnt   <= w_hold - 1'b1;
            pulse <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CH_ACTIVE: begin
          if (cnt == '0) begin
            st    <= CH_IDLE;
            pulse <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st    <= CH_IDLE;
          pulse <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/evmap_level_bank.sv
// Flip-flop style outputs: clear dominates set.
module evmap_level_bank #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] set_v,
  input  logic [N_OUT-1:0] clr_v,
  output logic [N_OUT-1:0] level
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)           level[i] <= 1'b0;
      else if (clr_v[i]) level[i] <= 1'b0;
      else if (set_v[i]) level[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/evmap_pulse_unit.sv
module evmap_pulse_unit #(
  parameter int N_OUT  = 4,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CODE_W-1:0]        evt_code,
  input  logic                     tbl_we,
  input  logic [CODE_W-1:0]        tbl_addr,
  input  logic [3*N_OUT:0]         tbl_wdata,
  input  logic                     cfg_we,
  input  logic [$clog2(N_OUT)-1:0] cfg_ch,
  input  logic [CNT_W-1:0]         cfg_delay,
  input  logic [CNT_W-1:0]         cfg_width,
  input  logic                     irq_clr,
  output logic [N_OUT-1:0]         pulse_out,
  output logic [N_OUT-1:0]         level_out,
  output logic                     irq_out
);
  localparam int ENT_W   = 3 * N_OUT + 1;
  localparam int SET_LO  = N_OUT;
  localparam int CLR_LO  = 2 * N_OUT;
  localparam int IRQ_BIT = 3 * N_OUT;

  logic [ENT_W-1:0] act;
  logic [CNT_W-1:0] delay_r [N_OUT];
  logic [CNT_W-1:0] width_r [N_OUT];

  evmap_table #(.CODE_W(CODE_W), .ENT_W(ENT_W)) u_table (
    .clk   (clk),
    .rst   (rst),
    .code  (evt_code),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .act   (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_OUT; i++) begin
        delay_r[i] <= '0;
        width_r[i] <= '0;
      end
    end else if (cfg_we) begin
      delay_r[cfg_ch] <= cfg_delay;
      width_r[cfg_ch] <= cfg_width;
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_chan
    evmap_pulse_chan #(.CNT_W(CNT_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .trig  (act[i]),
      .delay (delay_r[i]),
      .width (width_r[i]),
      .pulse (pulse_out[i])
    );
  end

  evmap_level_bank #(.N_OUT(N_OUT)) u_levels (
    .clk   (clk),
    .rst   (rst),
    .set_v (act[SET_LO +: N_OUT]),
    .clr_v (act[CLR_LO +: N_OUT]),
    .level (level_out)
  );

  always_ff @(posedge clk) begin
    if (rst)               irq_out <= 1'b0;
    else if (act[IRQ_BIT]) irq_out <= 1'b1;
    else if (irq_clr)      irq_out <= 1'b0;
  end
endmodule

// File: rtl/evmap_pulse_unit_chk.sv
module evmap_pulse_unit_chk #(
  parameter int N_OUT  = 4,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] evt_code,
  input logic              irq_clr,
  input logic [N_OUT-1:0]  pulse_out,
  input logic [N_OUT-1:0]  level_out,
  input logic              irq_out
);
  assert_level_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_code, 2) == '0) |-> $stable(level_out));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !irq_clr) |=> irq_out);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && ($past(evt_code) == '0)) |=> !irq_out);

  assert_idle_code_no_irq_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> ($past(evt_code, 2) != '0));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (pulse_out == '0 && level_out == '0 && !irq_out));
endmodule

bind evmap_pulse_unit evmap_pulse_unit_chk #(.N_OUT(N_OUT), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_code  (evt_code),
  .irq_clr   (irq_clr),
  .pulse_out (pulse_out),
  .level_out (level_out),
  .irq_out   (irq_out)
);

// File: tb/evmap_pulse_unit_bench.sv
module evmap_pulse_unit_bench;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int TW = 16;
  localparam int EW = 3 * N + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] evt_code = '0;
  logic          tbl_we = 1'b0;
  logic [CW-1:0] tbl_addr = '0;
  logic [EW-1:0] tbl_wdata = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_ch = '0;
  logic [TW-1:0] cfg_delay = '0;
  logic [TW-1:0] cfg_width = '0;
  logic          irq_clr = 1'b0;
  logic [N-1:0]  pulse_out;
  logic [N-1:0]  level_out;
  logic          irq_out;

  always #2 clk = ~clk;

  evmap_pulse_unit u_evmap_pulse_unit (
    .clk(clk), .rst(rst), .evt_code(evt_code), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_delay(cfg_delay), .cfg_width(cfg_width),
    .irq_clr(irq_clr), .pulse_out(pulse_out), .level_out(level_out),
    .irq_out(irq_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural reference: pulse windows held as absolute edge numbers.
  logic [EW-1:0] m_tbl [256];
  int            m_d [N];
  int            m_w [N];
  int            m_rise [N];
  int            m_fall [N];
  bit [N-1:0]    m_lvl;
  bit            m_irq;
  bit [EW-1:0]   m_stage;
  int            k = 0;
  int            hi_cnt [N];
  int            first_hi [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  task automatic model_edge();
    bit [EW-1:0] a;
    k++;
    if (tbl_we) begin end
    if (rst) begin
      m_lvl = '0; m_irq = 1'b0; m_stage = '0;
      for (int i = 0; i < N; i++) begin
        m_d[i] = 0; m_w[i] = 0; m_rise[i] = 0; m_fall[i] = 0;
      end
    end else begin
      a = m_stage;
      for (int i = 0; i < N; i++)
        if (a[i]) begin
          m_rise[i] = k + m_d[i];
          m_fall[i] = k + m_d[i] + m_w[i];
        end
      m_lvl = (m_lvl | a[N +: N]) & ~a[2*N +: N];
      if (a[3*N])       m_irq = 1'b1;
      else if (irq_clr) m_irq = 1'b0;
      m_stage = (evt_code != 0) ? m_tbl[evt_code] : '0;
      if (cfg_we) begin
        m_d[cfg_ch] = int'(cfg_delay);
        m_w[cfg_ch] = int'(cfg_width);
      end
    end
    if (tbl_we) m_tbl[tbl_addr] = tbl_wdata;
  endtask

  task automatic compare();
    bit [N-1:0] ep;
    for (int i = 0; i < N; i++) begin
      ep[i] = (k >= m_rise[i]) && (k < m_fall[i]);
      if (pulse_out[i]) begin
        if (hi_cnt[i] == 0) first_hi[i] = k;
        hi_cnt[i]++;
      end
    end
    chk(pulse_out == ep, "R3 pulse timing", int'(pulse_out), int'(ep));
    chk(level_out == m_lvl, "R7 level", int'(level_out), int'(m_lvl));
    chk(irq_out == m_irq, "R9 irq", int'(irq_out), int'(m_irq));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clear_stats();
    for (int i = 0; i < N; i++) begin hi_cnt[i] = 0; first_hi[i] = -1; end
  endtask

  task automatic put_entry(input int code, input logic [EW-1:0] d);
    tbl_we = 1'b1; tbl_addr = CW'(code); tbl_wdata = d;
    step();
    tbl_we = 1'b0;
  endtask

  task automatic put_cfg(input int ch, input int d, input int w);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_delay = TW'(d); cfg_width = TW'(w);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic send(input int code);
    evt_code = CW'(code);
    step();
    evt_code = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k0;
    for (int i = 0; i < 256; i++) m_tbl[i] = '0;
    clear_stats();
    idle(3);
    rst = 1'b0;
    // R11: quiet after reset
    chk(pulse_out == 0 && level_out == 0 && irq_out == 0, "R11 reset state",
        int'({irq_out, level_out, pulse_out}), 0);
    for (int i = 0; i < 256; i++) put_entry(i, '0);

    // R1: entry 0 fully loaded, idle code must still do nothing
    put_entry(0, 13'h1FFF);
    put_cfg(0, 0, 3);
    idle(6);
    chk(pulse_out == 0 && level_out == 0 && irq_out == 0, "R1 idle code",
        int'({irq_out, level_out, pulse_out}), 0);

    // R3 R4 R5: code 0x10 pulses all four outputs and flags irq (R2 layout)
    put_cfg(0, 3, 2);
    put_cfg(1, 0, 1);
    put_cfg(2, 5, 0);
    put_cfg(3, 1, 4);
    put_entry(8'h10, 13'h100F);
    clear_stats();
    send(8'h10);
    k0 = k;
    idle(12);
    chk(first_hi[0] - k0 == 4, "R3 delay 3", first_hi[0] - k0, 4);
    chk(first_hi[1] - k0 == 1, "R3 delay 0", first_hi[1] - k0, 1);
    chk(hi_cnt[0] == 2, "R4 width 2", hi_cnt[0], 2);
    chk(hi_cnt[3] == 4, "R4 width 4", hi_cnt[3], 4);
    chk(hi_cnt[2] == 0, "R5 width 0", hi_cnt[2], 0);
    chk(irq_out == 1'b1, "R9 irq raised", int'(irq_out), 1);

    // R9: clear, then set and clear in the same edge
    irq_clr = 1'b1; step(); irq_clr = 1'b0; step();
    chk(irq_out == 1'b0, "R9 irq cleared", int'(irq_out), 0);
    evt_code = 8'h10; step(); evt_code = '0;
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    chk(irq_out == 1'b1, "R9 set beats clear", int'(irq_out), 1);
    idle(10);

    // R6: retrigger during the delay restarts it
    put_cfg(0, 4, 3);
    clear_stats();
    send(8'h10);
    k0 = k;
    step();
    send(8'h10);
    idle(12);
    chk(first_hi[0] - k0 == 7, "R6 restart delay", first_hi[0] - k0, 7);
    chk(hi_cnt[0] == 3, "R6 single pulse", hi_cnt[0], 3);

    // R7 R8: levels; 0x23 sets and resets output 1
    put_entry(8'h21, 13'h0050);
    put_entry(8'h24, 13'h0020);
    put_entry(8'h23, 13'h02A0);
    put_entry(8'h22, 13'h0100);
    send(8'h21); send(8'h24); send(8'h23);
    idle(2);
    chk(level_out == 4'b1101, "R8 reset wins", int'(level_out), 'hd);
    send(8'h22);
    idle(2);
    chk(level_out == 4'b1100, "R7 reset level", int'(level_out), 'hc);

    // R10: one code pulses output 1, sets output 0, resets output 2
    put_entry(8'h30, 13'h0412);
    put_cfg(1, 0, 1);
    clear_stats();
    send(8'h30);
    idle(3);
    chk(level_out == 4'b1001, "R10 mixed levels", int'(level_out), 'h9);
    chk(hi_cnt[1] == 1 && hi_cnt[0] == 0, "R10 pulse only on 1", hi_cnt[1], 1);

    // Random traffic against the reference, with one mid-run reset (R11)
    for (int c = 1; c < 16; c++) put_entry(c, EW'($urandom));
    for (int i = 0; i < N; i++) put_cfg(i, $urandom_range(5), $urandom_range(4));
    for (int n = 0; n < 3000; n++) begin
      evt_code = ($urandom_range(9) < 3) ? '0 : CW'($urandom_range(15));
      irq_clr  = ($urandom_range(9) == 0);
      if ($urandom_range(49) == 0) begin
        cfg_we = 1'b1; cfg_ch = 2'($urandom_range(3));
        cfg_delay = TW'($urandom_range(5)); cfg_width = TW'($urandom_range(4));
      end
      if ($urandom_range(59) == 0) begin
        tbl_we = 1'b1; tbl_addr = CW'($urandom_range(15)); tbl_wdata = EW'($urandom);
      end
      if (n == 1500) rst = 1'b1;
      step();
      cfg_we = 1'b0; tbl_we = 1'b0; rst = 1'b0;
    end
    evt_code = '0; irq_clr = 1'b0;
    idle(10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule